// File: doc/BRIEF.md
# Switching Fault Qualification Filter

This block sits between the analog protection comparators of a switching power converter and its start-up sequencer. It filters their noisy flags so that a single glitch never trips a fault. Two flags are handled. The over-voltage flag is read only while the power switch is off, inside a short strobe window that opens a fixed delay after the gate turns off. The over-current flag is read only while the gate is on.

Every oscillator cycle, marked by a one-clock cycle-start pulse, ends with a verdict: the cycle either tripped or it was clean. Over-voltage is declared after a run of consecutive tripped cycles, and it goes to the sequencer as a one-clock pulse. A first over-current trip raises a warning flag. A second trip in the very next cycle latches a shutdown level. That shutdown stays set until the supply supervisor pulses its clear input, which it does when the supply drops below its undervoltage-off level. A clean cycle throws away any partial run in either path.

The default configuration assumes a 10 MHz clock. With it, the strobe opens 5 clocks after the gate falls and stays open for 22 clocks. Four tripped cycles qualify an over-voltage fault, and two qualify an over-current shutdown.

Top module: `fault_qual_filter`

## Requirements
- R1: While reset is asserted, and after its release until stimulus arrives, fault_warn, ovp_fault and ocp_shutdown are all 0. Reset clears every count, the warning state and the latch.
- R2: Off-time cycles are numbered j = 0, 1, 2, and so on, where j = 0 is the first clock in which gate_on is low. ovp_trip counts toward the current oscillator cycle only when it is high in a clock with j from STROBE_DELAY to STROBE_DELAY+STROBE_LEN-1, which is 5 to 26 by default. It is ignored in every other clock and throughout on-time.
- R3: ovp_fault is high for exactly one clock, in the clock after the cycle_start that closes the OVP_RUN-th consecutive tripped cycle (4 by default). It is never high at any other time.
- R4: An oscillator cycle with no strobed over-voltage trip resets the over-voltage run to zero. For example, three tripped cycles, one clean cycle and three tripped cycles produce no fault.
- R5: After ovp_fault fires, the run restarts from zero. Seven consecutive tripped cycles therefore give exactly one pulse.
- R6: fault_warn becomes 1 in the clock after the cycle_start that closes a cycle with an over-current trip, when no run is in progress. It returns to 0 after the next cycle_start if the cycle that has just closed is clean.
- R7: When OCP_RUN consecutive cycles (2 by default) contain an over-current trip, ocp_shutdown rises in the clock after the closing cycle_start, and fault_warn falls at the same time.
- R8: Once set, ocp_shutdown stays 1 whatever ocp_trip does, and fault_warn stays 0, until supply_clr is sampled high. In the clock after that, both outputs are 0.
- R9: ocp_trip is ignored while gate_on is low. A trip counts only when it is sampled together with gate_on high, including the clock in which cycle_start is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-clock pulse at the start of each oscillator cycle |
| gate_on | input | 1 | High while the power switch is on |
| ovp_trip | input | 1 | Raw over-voltage comparator output |
| ocp_trip | input | 1 | Raw second-level over-current comparator output |
| supply_clr | input | 1 | Supply-supervisor clear of the over-current latch |
| fault_warn | output | 1 | Over-current warning: one trip seen, run in progress |
| ovp_fault | output | 1 | One-clock qualified over-voltage fault pulse |
| ocp_shutdown | output | 1 | Latched over-current shutdown level |

## Verification
Every verdict lands at a cycle_start edge. ovp_fault, fault_warn and ocp_shutdown therefore change only in the clock that follows that edge, and the bench reads them there, at the falling clock edge of cycle index 1 of each stimulus period. A fault pulse seen at any other position is counted as stray and reported against R3.

Two points need care:
- **Strobe edges.** The strobe boundaries are probed by moving a one-clock over-voltage pulse through every position of the cycle. Each position gets four tripped cycles, so a pulse appears after the first clean flush cycle only when the position lies inside the window.
- **Run patterns.** All 128 seven-cycle trip patterns are played for each path. The expected pulse count, warning and latch state are worked out in the bench from the run rules, cycle by cycle.

// File: rtl/fqf_pkg.sv
`timescale 1ns/1ps
package fqf_pkg;

   typedef enum logic {
      QUAL_PULSE = 1'b0,
      QUAL_LATCH = 1'b1
   } qual_mode_e;

   function automatic int cnt_width(input int max_value);
      return (max_value < 2) ? 1 : $clog2(max_value + 1);
   endfunction

endpackage

// File: rtl/fqf_strobe_window.sv
`timescale 1ns/1ps
module fqf_strobe_window #(
   parameter int DELAY = 5,
   parameter int LEN   = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_on,
   output logic strobe
);
   localparam int LAST = DELAY + LEN;
   localparam int CW   = fqf_pkg::cnt_width(LAST);
   localparam logic [CW-1:0] OPEN_AT  = CW'(DELAY);
   localparam logic [CW-1:0] CLOSE_AT = CW'(LAST);
   localparam logic [CW-1:0] ONE      = CW'(1);

   logic          gate_q;
   logic [CW-1:0] off_cnt_q;
   logic          gate_fall;

   assign gate_fall = gate_q & ~gate_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q    <= 1'b0;
         off_cnt_q <= '0;
      end else begin
         gate_q <= gate_on;
         if (gate_on) begin
            off_cnt_q <= '0;
         end else if (gate_fall) begin
            off_cnt_q <= ONE;
         end else if ((off_cnt_q != '0) && (off_cnt_q < CLOSE_AT)) begin
            off_cnt_q <= off_cnt_q + ONE;
         end
      end
   end

   assign strobe = ~gate_on && (off_cnt_q >= OPEN_AT) && (off_cnt_q < CLOSE_AT);

endmodule

// File: rtl/fqf_run_qualifier.sv
`timescale 1ns/1ps
module fqf_run_qualifier #(
   parameter int                  RUN  = 4,
   parameter fqf_pkg::qual_mode_e MODE = fqf_pkg::QUAL_PULSE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cycle_start,
   input  logic sample,
   output logic busy,
   output logic fire
);
   localparam int CW = fqf_pkg::cnt_width(RUN);
   localparam logic [CW-1:0] RUN_LAST = CW'(RUN - 1);
   localparam logic [CW-1:0] ONE      = CW'(1);

   // Trip seen in the oscillator cycle in progress; samples taken in the
   // cycle_start clock belong to the new cycle.
   logic hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
      end else if (clr) begin
         hit_q <= 1'b0;
      end else if (cycle_start) begin
         hit_q <= sample;
      end else begin
         hit_q <= hit_q | sample;
      end
   end

   generate
      if (MODE == fqf_pkg::QUAL_LATCH) begin : g_latch
         logic [CW-1:0] run_q;
         logic          latched_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q     <= '0;
               latched_q <= 1'b0;
            end else if (clr) begin
               run_q     <= '0;
               latched_q <= 1'b0;
            end else if (cycle_start && !latched_q) begin
               if (hit_q) begin
                  if (run_q == RUN_LAST) begin
                     run_q     <= '0;
                     latched_q <= 1'b1;
                  end else begin
                     run_q <= run_q + ONE;
                  end
               end else begin
                  run_q <= '0;
               end
            end
         end

         assign busy = (run_q != '0);
         assign fire = latched_q;
      end else begin : g_pulse
         logic [CW-1:0] run_q;
         logic          pulse_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q   <= '0;
               pulse_q <= 1'b0;
            end else if (clr) begin
               run_q   <= '0;
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= 1'b0;
               if (cycle_start) begin
                  if (hit_q) begin
                     if (run_q == RUN_LAST) begin
                        run_q   <= '0;
                        pulse_q <= 1'b1;
                     end else begin
                        run_q <= run_q + ONE;
                     end
                  end else begin
                     run_q <= '0;
                  end
               end
            end
         end

         assign busy = (run_q != '0);
         assign fire = pulse_q;
      end
   endgenerate

endmodule

// File: rtl/fault_qual_filter.sv
`timescale 1ns/1ps
module fault_qual_filter #(
   parameter int STROBE_DELAY = 5,
   parameter int STROBE_LEN   = 22,
   parameter int OVP_RUN      = 4,
   parameter int OCP_RUN      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cycle_start,
   input  logic gate_on,
   input  logic ovp_trip,
   input  logic ocp_trip,
   input  logic supply_clr,
   output logic fault_warn,
   output logic ovp_fault,
   output logic ocp_shutdown
);

   if (STROBE_DELAY < 1) begin : g_bad_delay
      $error("fault_qual_filter: STROBE_DELAY must be at least 1");
   end
   if (STROBE_LEN < 1) begin : g_bad_len
      $error("fault_qual_filter: STROBE_LEN must be at least 1");
   end
   if (OVP_RUN < 1 || OCP_RUN < 1) begin : g_bad_run
      $error("fault_qual_filter: run lengths must be at least 1");
   end

   logic strobe;
   logic ovp_sample;
   logic ocp_sample;
   logic ovp_busy;

   fqf_strobe_window #(
      .DELAY (STROBE_DELAY),
      .LEN   (STROBE_LEN)
   ) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_on (gate_on),
      .strobe  (strobe)
   );

   assign ovp_sample = ovp_trip & strobe;
   assign ocp_sample = ocp_trip & gate_on;

   fqf_run_qualifier #(
      .RUN  (OVP_RUN),
      .MODE (fqf_pkg::QUAL_PULSE)
   ) u_ovp (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (1'b0),
      .cycle_start (cycle_start),
      .sample      (ovp_sample),
      .busy        (ovp_busy),
      .fire        (ovp_fault)
   );

   fqf_run_qualifier #(
      .RUN  (OCP_RUN),
      .MODE (fqf_pkg::QUAL_LATCH)
   ) u_ocp (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (supply_clr),
      .cycle_start (cycle_start),
      .sample      (ocp_sample),
      .busy        (fault_warn),
      .fire        (ocp_shutdown)
   );

endmodule

// File: rtl/fault_qual_filter_chk.sv
`timescale 1ns/1ps
module fault_qual_filter_chk (
   input logic clk,
   input logic rst_n,
   input logic cycle_start,
   input logic gate_on,
   input logic supply_clr,
   input logic strobe,
   input logic ovp_busy,
   input logic fault_warn,
   input logic ovp_fault,
   input logic ocp_shutdown
);

   a_r2_strobe_in_off_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> (!gate_on && $past(!gate_on)));

   a_r3_single_clock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_fault |=> !ovp_fault);

   a_r3_pulse_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_fault |-> $past(cycle_start));

   a_r5_run_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_fault |-> !ovp_busy);

   a_r6_warn_moves_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_warn != $past(fault_warn)) |-> ($past(cycle_start) || $past(supply_clr)));

   a_r7_latch_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ocp_shutdown) |-> $past(cycle_start));

   a_r7_no_warn_latched: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_shutdown |-> !fault_warn);

   a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ocp_shutdown && !supply_clr) |=> ocp_shutdown);

   a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      supply_clr |=> (!ocp_shutdown && !fault_warn));

endmodule

bind fault_qual_filter fault_qual_filter_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cycle_start  (cycle_start),
   .gate_on      (gate_on),
   .supply_clr   (supply_clr),
   .strobe       (strobe),
   .ovp_busy     (ovp_busy),
   .fault_warn   (fault_warn),
   .ovp_fault    (ovp_fault),
   .ocp_shutdown (ocp_shutdown)
);

// File: tb/fault_qual_filter_test.sv
`timescale 1ns/1ps
module fault_qual_filter_test;
   localparam int CLK_PERIOD = 10;
   localparam int DLY        = 5;
   localparam int WLEN       = 22;
   localparam int OVP_N      = 4;
   localparam int OCP_N      = 2;
   localparam int ON_CLK     = 8;
   localparam int PERIOD     = 40;
   localparam int PAT_BITS   = 7;
   localparam int WD_LIMIT   = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cycle_start = 1'b0;
   logic gate_on = 1'b0;
   logic ovp_trip = 1'b0;
   logic ocp_trip = 1'b0;
   logic supply_clr = 1'b0;
   logic fault_warn;
   logic ovp_fault;
   logic ocp_shutdown;

   int checks = 0;
   int failures = 0;
   int stray = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fault_qual_filter #(
      .STROBE_DELAY (DLY),
      .STROBE_LEN   (WLEN),
      .OVP_RUN      (OVP_N),
      .OCP_RUN      (OCP_N)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cycle_start  (cycle_start),
      .gate_on      (gate_on),
      .ovp_trip     (ovp_trip),
      .ocp_trip     (ocp_trip),
      .supply_clr   (supply_clr),
      .fault_warn   (fault_warn),
      .ovp_fault    (ovp_fault),
      .ocp_shutdown (ocp_shutdown)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One oscillator period. The outputs read at index 1 reflect the verdict
   // on the period before this one.
   task automatic run_cycle(input int ovp_pos, input int ocp_pos,
                            output logic warn_s, output logic shut_s,
                            output int pulses);
      pulses = 0;
      warn_s = 1'b0;
      shut_s = 1'b0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         if (i == 1) begin
            warn_s = fault_warn;
            shut_s = ocp_shutdown;
         end
         if (ovp_fault) begin
            if (i == 1) pulses++;
            else stray++;
         end
         cycle_start = (i == 0);
         gate_on     = (i < ON_CLK);
         ovp_trip    = (i == ovp_pos);
         ocp_trip    = (i == ocp_pos);
      end
   endtask

   task automatic clear_pulse();
      @(negedge clk);
      cycle_start = 1'b0;
      gate_on     = 1'b0;
      ovp_trip    = 1'b0;
      ocp_trip    = 1'b0;
      supply_clr  = 1'b1;
      @(negedge clk);
      check("R8 clear shutdown", int'(ocp_shutdown), 0);
      check("R8 clear warn", int'(fault_warn), 0);
      supply_clr = 1'b0;
   endtask

   function automatic int ovp_expected(input int pat);
      int run = 0;
      int n = 0;
      for (int b = 0; b < PAT_BITS; b++) begin
         if (pat[b]) begin
            run++;
            if (run == OVP_N) begin
               n++;
               run = 0;
            end
         end else begin
            run = 0;
         end
      end
      return n;
   endfunction

   task automatic ovp_pattern(input int pat, input string tag);
      logic w, s;
      int   p;
      int   total = 0;
      for (int b = 0; b <= PAT_BITS; b++) begin
         run_cycle((b < PAT_BITS && pat[b]) ? ON_CLK + 10 : -1, -1, w, s, p);
         total += p;
      end
      check(tag, total, ovp_expected(pat));
   endtask

   task automatic ocp_pattern(input int pat);
      logic w, s;
      int   p;
      int   run = 0;
      int   lat = 0;
      for (int b = 0; b <= PAT_BITS; b++) begin
         run_cycle(-1, (b < PAT_BITS && pat[b]) ? 3 : -1, w, s, p);
         if (b >= 1) begin
            if (lat == 0) begin
               if (pat[b-1]) begin
                  run++;
                  if (run == OCP_N) begin
                     lat = 1;
                     run = 0;
                  end
               end else begin
                  run = 0;
               end
            end
            if (lat != 0) begin
               check("R8 shutdown held", int'(s), 1);
               check("R7 warn low when latched", int'(w), 0);
            end else begin
               check("R7 shutdown state", int'(s), 0);
               check("R6 warn state", int'(w), (run != 0) ? 1 : 0);
            end
         end
      end
      clear_pulse();
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic w, s;
      int   p, total;
      repeat (3) @(negedge clk);
      check("R1 warn in reset", int'(fault_warn), 0);
      check("R1 ovp_fault in reset", int'(ovp_fault), 0);
      check("R1 shutdown in reset", int'(ocp_shutdown), 0);
      rst_n = 1'b1;
      run_cycle(-1, -1, w, s, p);
      run_cycle(-1, -1, w, s, p);
      check("R1 warn after reset", int'(w), 0);
      check("R1 shutdown after reset", int'(s), 0);
      check("R1 no pulse after reset", p, 0);

      // R2: strobe window sweep across every clock of the period
      for (int pos = 0; pos < PERIOD; pos++) begin
         total = 0;
         for (int k = 0; k < OVP_N; k++) begin
            run_cycle(pos, -1, w, s, p);
            total += p;
         end
         run_cycle(-1, -1, w, s, p);
         total += p;
         check("R2 strobe window", total,
               ((pos - ON_CLK >= DLY) && (pos - ON_CLK <= DLY + WLEN - 1)) ? 1 : 0);
      end

      // R3: every seven-cycle over-voltage pattern
      for (int pat = 0; pat < (1 << PAT_BITS); pat++) begin
         ovp_pattern(pat, "R3 pulse count");
      end
      ovp_pattern('b1110111, "R4 clean cycle resets run");
      ovp_pattern('b1111111, "R5 run restarts after fault");
      check("R3 stray pulses", stray, 0);

      // R9: over-current flag position sweep
      for (int pos = 0; pos < PERIOD; pos++) begin
         run_cycle(-1, pos, w, s, p);
         run_cycle(-1, -1, w, s, p);
         check("R9 trip only with gate on", int'(w), (pos < ON_CLK) ? 1 : 0);
         run_cycle(-1, -1, w, s, p);
         check("R6 warn cleared by clean cycle", int'(w), 0);
         check("R9 no shutdown from single trip", int'(s), 0);
      end

      // R6/R7/R8: every seven-cycle over-current pattern
      for (int pat = 0; pat < (1 << PAT_BITS); pat++) begin
         ocp_pattern(pat);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule